// File: doc/BRIEF.md
# Vertical Frame Sync Correlator with Line Counter

This block finds where a video frame starts once horizontal lock is already in place. A composite-video sample stream arrives on a valid/ready interface, and a one-cycle line strobe marks the first sample of every line. For each line the block adds and subtracts sample sums over four fixed spans that sit right after the line start. Together these sums form a partial correlation with the vertical-sync pulse shape. The block then adds the partial of the line just closed to the partials of the two lines before it, which gives a three-line score.

After reset the block searches. It scores one full frame's worth of lines and keeps the best three-line window. At the end of that frame it loads a frame line counter so that the last line of the best window becomes frame line `SYNC_LAST`. From then on the counter advances on every strobe. When the counter wraps to zero the block enters its steady video state. On frame line `SYNC_LAST` of every tracked frame it captures two levels from fixed sample positions: one inside the low pulse and one inside the blanking gap. A later gain stage uses these levels.

The sample input never stalls. `s_ready` is high whenever reset is low, so a sample is consumed in every cycle where `s_valid` is high. A cycle with `s_valid` low carries no sample, and the block ignores its data.

Top module: `vsync_frame_lock`

## Requirements
- R1: `s_ready` equals the inverse of `rst`. A sample counts only in a cycle with `s_valid` high, and data in cycles with `s_valid` low has no effect.
- R2: Each line's partial score uses the accepted samples of that line, counted from index 0 at the strobe. The sample accepted in the strobe cycle has index 0. The sign of each sample depends on its index:
  - indices [0,NL) are subtracted;
  - indices [NL,NL+NH) are added;
  - indices [NL+NH,2NL+NH) are added;
  - indices [2NL+NH,2NL+2NH) are subtracted;
  - samples at index 2NL+2NH and above are ignored.
- R3: Search lines are numbered from 0 at the first strobe after reset. The window ending on line k (k ≥ 2) scores the sum of the partials of lines k, k-1 and k-2. Over lines 0 to LINES-1 the block picks the highest window. On a tie, the earliest window wins.
- R4: `sync_state` is 0 in search, 1 in counting and 2 in video. While searching, `line_num` stays 0.
- R5: The search ends at the strobe that opens search line LINES. At that strobe `line_num` loads (SYNC_LAST + LINES − b) mod LINES, where b is the last line of the best window. The state then leaves search.
- R6: Outside search, each strobe advances `line_num` by one, and LINES−1 wraps to 0.
- R7: The block enters video (2) when `line_num` becomes 0. This includes the case of a preset of 0, which goes straight from search to video. Video is held until reset.
- R8: Outside search, on frame line SYNC_LAST, the sample at index NL/2 loads `vs_low` and the sample at index NL+NH/2 loads `vs_blank`. `lvl_valid` goes high with the blank capture and stays high.
- R9: A synchronous reset returns the block to search, with `line_num` 0 and `lvl_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_strobe | input | 1 | One-cycle pulse that marks the first sample of a line |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, high whenever reset is low |
| s_data | input | DW | Signed video sample |
| sync_state | output | 2 | 0 search, 1 counting, 2 video |
| line_num | output | $clog2(LINES) | Frame line counter |
| vs_low | output | DW | Captured low-pulse level |
| vs_blank | output | DW | Captured blanking level |
| lvl_valid | output | 1 | The levels have been captured at least once |

## Verification
In some cycles two functions act at once. The strobe that opens a line also carries sample 0 of that line, so in the same cycle the block closes one accumulation and starts the next. The bench puts a valid sample on every strobe and puts bubbles filled with garbage data inside lines, so any leak would show up in the chosen preset. In a second case the search decision and the entry to video fall on the same edge. The frame is built so that the best window ends on search line SYNC_LAST and a later identical window ties with it. The preset is therefore 0, and the bench expects state 2 with line 0 right after the closing strobe, with no counting phase in between.

// File: rtl/vsfl_pkg.sv
package vsfl_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_COUNT  = 2'd1,
    ST_VIDEO  = 2'd2
  } vs_state_e;
endpackage

// File: rtl/vs_line_corr.sv
module vs_line_corr #(
  parameter int DW = 10,
  parameter int NL = 388,
  parameter int NH = 67,
  localparam int SPAN = 2*NL + 2*NH,
  localparam int IW = $clog2(SPAN + 1),
  localparam int AW = DW + IW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_strobe,
  input  logic                 s_valid,
  input  logic signed [DW-1:0] s_data,
  output logic signed [AW-1:0] acc,
  output logic [IW-1:0]        cur_idx
);
  logic [IW-1:0]        sidx;
  logic signed [AW-1:0] dext;
  logic signed [AW-1:0] contrib;

  assign cur_idx = line_strobe ? '0 : sidx;
  assign dext    = {{(AW-DW){s_data[DW-1]}}, s_data};

  // sign of the pattern tap for the sample index
  always_comb begin
    if (cur_idx < IW'(NL))              contrib = -dext;
    else if (cur_idx < IW'(NL + NH))    contrib = dext;
    else if (cur_idx < IW'(2*NL + NH))  contrib = dext;
    else if (cur_idx < IW'(SPAN))       contrib = -dext;
    else                                contrib = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      sidx <= '0;
    end else if (line_strobe) begin
      acc  <= s_valid ? contrib : '0;
      sidx <= s_valid ? IW'(1) : '0;
    end else if (s_valid) begin
      acc <= acc + contrib;
      if (sidx < IW'(SPAN)) sidx <= sidx + IW'(1);
    end
  end

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
    (line_strobe && !s_valid) |=> (acc == '0)); // R2
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!line_strobe && !s_valid) |=> $stable(acc)); // R1
  AST_IDX_SAT: assert property (@(posedge clk) disable iff (rst)
    sidx <= IW'(SPAN)); // R2
endmodule

// File: rtl/vs_frame_search.sv
module vs_frame_search #(
  parameter int AW = 21,
  parameter int LINES = 525,
  parameter int SYNC_LAST = 6,
  localparam int LW = $clog2(LINES),
  localparam int CW = $clog2(LINES + 1),
  localparam int PW = $clog2(LINES + SYNC_LAST + 1),
  localparam int SW = AW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_strobe,
  input  logic                 searching,
  input  logic signed [AW-1:0] acc,
  output logic                 done,
  output logic [LW-1:0]        preset
);
  logic signed [AW-1:0] p0, p1;
  logic signed [SW-1:0] score, best;
  logic [CW-1:0]        lcnt, kidx, bidx, bfin;
  logic                 have, win_ok, take;
  logic [PW-1:0]        sum;

  assign score  = SW'(acc) + SW'(p0) + SW'(p1);
  assign kidx   = lcnt - CW'(1);
  assign win_ok = searching && line_strobe && (lcnt >= CW'(3));
  assign take   = win_ok && (!have || (score > best));
  assign done   = searching && line_strobe && (lcnt == CW'(LINES));
  assign bfin   = take ? kidx : bidx;
  assign sum    = PW'(SYNC_LAST) + PW'(LINES) - PW'(bfin);
  assign preset = (sum >= PW'(LINES)) ? LW'(sum - PW'(LINES)) : LW'(sum);

  always_ff @(posedge clk) begin
    if (rst) begin
      p0   <= '0;
      p1   <= '0;
      lcnt <= '0;
      have <= 1'b0;
      best <= '0;
      bidx <= '0;
    end else begin
      if (line_strobe) begin
        p1 <= p0;
        p0 <= acc;
      end
      if (searching && line_strobe && (lcnt < CW'(LINES))) lcnt <= lcnt + CW'(1);
      if (take) begin
        have <= 1'b1;
        best <= score;
        bidx <= kidx;
      end
    end
  end

  AST_BEST_RANGE: assert property (@(posedge clk) disable iff (rst)
    have |-> (bidx >= CW'(2) && bidx < CW'(LINES))); // R3
  AST_BEST_MONO: assert property (@(posedge clk) disable iff (rst)
    ($past(have) && have) |-> (best >= $past(best))); // R3
endmodule

// File: rtl/vs_line_fsm.sv
module vs_line_fsm
  import vsfl_pkg::*;
#(
  parameter int LINES = 525,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_strobe,
  input  logic          done,
  input  logic [LW-1:0] preset,
  output vs_state_e     state,
  output logic [LW-1:0] line_num
);
  logic [LW-1:0] nxt;

  assign nxt = (line_num == LW'(LINES - 1)) ? '0 : line_num + LW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SEARCH;
      line_num <= '0;
    end else begin
      case (state)
        ST_SEARCH: if (done) begin
          line_num <= preset;
          state    <= (preset == '0) ? ST_VIDEO : ST_COUNT;
        end
        default: if (line_strobe) begin
          line_num <= nxt;
          if (nxt == '0) state <= ST_VIDEO;
        end
      endcase
    end
  end

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    line_num < LW'(LINES)); // R6
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (state != ST_SEARCH && line_strobe) |=>
      (line_num == (($past(line_num) == LW'(LINES - 1)) ? '0 : $past(line_num) + LW'(1)))); // R6
  AST_SEARCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH) |-> (line_num == '0)); // R4
  AST_VIDEO_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT && line_strobe && line_num == LW'(LINES - 1)) |=> (state == ST_VIDEO)); // R7
  AST_VIDEO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VIDEO) |=> (state == ST_VIDEO)); // R7
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT) |-> (line_num != '0)); // R7
endmodule

// File: rtl/vs_level_grab.sv
module vs_level_grab #(
  parameter int DW = 10,
  parameter int IW = 10,
  parameter int LW = 10,
  parameter int SYNC_LAST = 6,
  parameter int LOW_IDX = 194,
  parameter int BLANK_IDX = 421
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tracking,
  input  logic                 s_valid,
  input  logic signed [DW-1:0] s_data,
  input  logic [IW-1:0]        cur_idx,
  input  logic [LW-1:0]        line_num,
  output logic signed [DW-1:0] vs_low,
  output logic signed [DW-1:0] vs_blank,
  output logic                 lvl_valid
);
  logic on_line;

  assign on_line = tracking && s_valid && (line_num == LW'(SYNC_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_low    <= '0;
      vs_blank  <= '0;
      lvl_valid <= 1'b0;
    end else begin
      if (on_line && cur_idx == IW'(LOW_IDX)) vs_low <= s_data;
      if (on_line && cur_idx == IW'(BLANK_IDX)) begin
        vs_blank  <= s_data;
        lvl_valid <= 1'b1;
      end
    end
  end

  AST_LVL_STICKY: assert property (@(posedge clk) disable iff (rst)
    lvl_valid |=> lvl_valid); // R8
  AST_LVL_SEARCH: assert property (@(posedge clk) disable iff (rst)
    !tracking |-> !lvl_valid); // R8
  AST_LVL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tracking |=> $stable(vs_low)); // R8
endmodule

// File: rtl/vsync_frame_lock.sv
module vsync_frame_lock
  import vsfl_pkg::*;
#(
  parameter int DW = 10,
  parameter int NL = 388,
  parameter int NH = 67,
  parameter int LINES = 525,
  parameter int SYNC_LAST = 6,
  localparam int SPAN = 2*NL + 2*NH,
  localparam int IW = $clog2(SPAN + 1),
  localparam int AW = DW + IW + 1,
  localparam int LW = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_strobe,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_data,
  output logic [1:0]           sync_state,
  output logic [LW-1:0]        line_num,
  output logic signed [DW-1:0] vs_low,
  output logic signed [DW-1:0] vs_blank,
  output logic                 lvl_valid
);
  logic signed [AW-1:0] acc;
  logic [IW-1:0]        cur_idx;
  logic                 done;
  logic [LW-1:0]        preset;
  vs_state_e            state;
  logic                 searching;

  assign s_ready    = ~rst;
  assign searching  = (state == ST_SEARCH);
  assign sync_state = state;

  vs_line_corr #(.DW(DW), .NL(NL), .NH(NH)) u_corr (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .s_valid(s_valid),
    .s_data(s_data), .acc(acc), .cur_idx(cur_idx)
  );

  vs_frame_search #(.AW(AW), .LINES(LINES), .SYNC_LAST(SYNC_LAST)) u_search (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .searching(searching),
    .acc(acc), .done(done), .preset(preset)
  );

  vs_line_fsm #(.LINES(LINES)) u_fsm (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .done(done),
    .preset(preset), .state(state), .line_num(line_num)
  );

  vs_level_grab #(
    .DW(DW), .IW(IW), .LW(LW), .SYNC_LAST(SYNC_LAST),
    .LOW_IDX(NL / 2), .BLANK_IDX(NL + NH / 2)
  ) u_lvl (
    .clk(clk), .rst(rst), .tracking(!searching), .s_valid(s_valid),
    .s_data(s_data), .cur_idx(cur_idx), .line_num(line_num),
    .vs_low(vs_low), .vs_blank(vs_blank), .lvl_valid(lvl_valid)
  );

  AST_DONE_LEAVES: assert property (@(posedge clk) disable iff (rst)
    done |=> (state != ST_SEARCH)); // R5
  AST_PRESET_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (preset < LW'(LINES))); // R5
endmodule

// File: tb/vsync_frame_lock_bench.sv
`timescale 1ns/1ps
module vsync_frame_lock_bench;
  localparam int DW = 10;
  localparam int NL = 4;
  localparam int NH = 2;
  localparam int LINES = 20;
  localparam int SLAST = 6;
  localparam int LLEN = 16;
  localparam int LW = $clog2(LINES);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_strobe = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [DW-1:0] s_data = '0;
  logic [1:0] sync_state;
  logic [LW-1:0] line_num;
  logic signed [DW-1:0] vs_low, vs_blank;
  logic lvl_valid;

  int total = 0;
  int bad = 0;

  int exp_st[$];
  int exp_ln[$];
  int exp_j[$];

  int part[0:63];
  int m_st, m_ln, m_best, m_bidx;
  bit m_have;

  always #2 clk = ~clk;

  vsync_frame_lock #(.DW(DW), .NL(NL), .NH(NH), .LINES(LINES), .SYNC_LAST(SLAST)) u_vsync_frame_lock (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .sync_state(sync_state), .line_num(line_num),
    .vs_low(vs_low), .vs_blank(vs_blank), .lvl_valid(lvl_valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic model_reset();
    m_st = 0; m_ln = 0; m_best = 0; m_bidx = 0; m_have = 0;
    exp_st.delete(); exp_ln.delete(); exp_j.delete();
  endtask

  // one line: model update for the opening strobe, then samples
  task automatic run_line(input int j, input bit sync, input int lowv, input int blankv);
    int v[LLEN];
    int p;
    for (int i = 0; i < LLEN; i++) begin
      if (i >= 2*NL + 2*NH) v[i] = 100 + j;
      else if (sync) begin
        if (i < NL) v[i] = lowv;
        else if (i < NL + NH) v[i] = blankv;
        else if (i < 2*NL + NH) v[i] = 0;
        else v[i] = lowv;
      end else v[i] = ((j*3 + i) % 11) - 5;
    end
    if (j >= 1 && j <= LINES && j - 1 >= 2) begin
      int sc;
      sc = part[j-1] + part[j-2] + part[j-3];
      if (!m_have || sc > m_best) begin m_best = sc; m_bidx = j - 1; m_have = 1; end
    end
    if (j == LINES) begin
      m_ln = (SLAST + LINES - m_bidx) % LINES;
      m_st = (m_ln == 0) ? 2 : 1;
    end else if (j > LINES) begin
      m_ln = (m_ln + 1) % LINES;
      if (m_ln == 0) m_st = 2;
    end
    exp_st.push_back(m_st); exp_ln.push_back(m_ln); exp_j.push_back(j);
    p = 0;
    for (int i = 0; i < 2*NL + 2*NH; i++)
      p += ((i < NL) || (i >= 2*NL + NH)) ? -v[i] : v[i];
    part[j] = p;
    for (int i = 0; i < LLEN; i++) begin
      if (i == 3 && (j % 2 == 1)) begin
        // bubble with garbage data must be ignored (R1)
        @(negedge clk);
        line_strobe = 1'b0; s_valid = 1'b0; s_data = -300;
      end
      @(negedge clk);
      line_strobe = (i == 0);
      s_valid = 1'b1;
      s_data = DW'(v[i]);
    end
  endtask

  task automatic end_stream();
    @(negedge clk);
    line_strobe = 1'b0; s_valid = 1'b0; s_data = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; line_strobe = 1'b0; s_valid = 1'b0;
    repeat (3) @(negedge clk);
    check({tag, " s_ready low in reset"}, s_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check({tag, " state after reset"}, sync_state, 0);
    check({tag, " line after reset"}, line_num, 0);
    check({tag, " lvl_valid after reset"}, lvl_valid, 0);
    check("R1 s_ready out of reset", s_ready, 1);
  endtask

  // monitor: compare after each strobe edge
  initial begin
    forever begin
      @(posedge clk);
      if (line_strobe && !rst) begin
        int es, el, ej;
        string tg;
        #1;
        if (exp_st.size() == 0) begin
          check("scoreboard underflow", 1, 0);
        end else begin
          es = exp_st.pop_front(); el = exp_ln.pop_front(); ej = exp_j.pop_front();
          if (ej < LINES) tg = "R4 search hold";
          else if (ej == LINES) tg = "R2 R3 R5 preset";
          else tg = "R6 R7 counting";
          check({tg, " state"}, sync_state, es);
          check({tg, " line"}, line_num, el);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    // scenario A: sync lines at search 9..11, preset 15, counting then video
    model_reset();
    do_reset("R9");
    for (int j = 0; j < 36; j++) begin
      bit sy;
      sy = (j >= 9 && j <= 11) || (j >= 29 && j <= 31);
      run_line(j, sy, -40, 7);
    end
    end_stream();
    check("R8 low level A", vs_low, -40);
    check("R8 blank level A", vs_blank, 7);
    check("R8 lvl_valid A", lvl_valid, 1);
    check("R7 video A", sync_state, 2);

    // scenario B: tie between 4..6 and 14..16, earliest wins, preset 0
    model_reset();
    do_reset("R9");
    for (int j = 0; j < 28; j++) begin
      bit sy;
      sy = (j >= 4 && j <= 6) || (j >= 14 && j <= 16) || (j >= 24 && j <= 26);
      run_line(j, sy, -50, 12);
    end
    end_stream();
    check("R8 low level B", vs_low, -50);
    check("R8 blank level B", vs_blank, 12);
    check("R8 lvl_valid B", lvl_valid, 1);
    check("R7 video B", sync_state, 2);
    check("R6 scoreboard drained", exp_st.size(), 0);
    finish_up();
  end
endmodule